// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block buffers received CAN frames between the bit-stream processor and the host register window. Payload bytes of each incoming frame are appended to a shared circular byte store. When the frame ends, a small descriptor is written to a separate descriptor store. The descriptor holds the number of bytes actually kept for that frame and a flag that records whether any byte was lost because the byte store was full. Messages are therefore kept whole and in arrival order, even though they differ in length.

The host always sees the oldest message. It reads that message's bytes through an offset input that is relative to the message start. The address wraps at the end of the byte store, so a message that straddles the end of storage reads as one contiguous block. The descriptor of the oldest message, meaning its length and overrun flag, is presented on dedicated outputs. A single-cycle release pulse frees the oldest message as a unit: its bytes and its descriptor are returned in one step. Byte occupancy, message count, a byte-store-full flag and a message-available flag are always visible.

If every descriptor slot is taken when a frame ends, that frame cannot be recorded. Its bytes are withdrawn from the byte store and a one-cycle drop pulse is raised.

Top module: `can_rx_msg_fifo`

## Requirements
- R1: After a synchronous active-low reset, byte_count and msg_count are 0, msg_avail is 0, and head_len and head_overrun are 0.
- R2: A byte offered with wr_byte_valid while byte_count is below 64 is stored at the tail of the byte store, and byte_count rises by one on the following cycle (absent a release).
- R3: A byte offered while byte_count equals 64 is discarded: byte_count stays at 64, and the overrun flag of the message being received is set.
- R4: When frame_end is pulsed and fewer than 32 messages are held, a descriptor is recorded and msg_count rises by one on the following cycle (absent a release). The descriptor holds the count of bytes stored since the previous frame end and the overrun flag. The length and overrun of the next message then start from 0.
- R5: When frame_end is pulsed while 32 messages are held, the frame is not recorded, its stored bytes are removed from byte_count, and msg_drop is high for exactly the next cycle.
- R6: A release_req pulse while at least one message is held lowers byte_count by the oldest message's length and msg_count by one, and makes the next message the oldest, all by the following cycle.
- R7: A release_req pulse while msg_count is 0 changes neither byte_count nor msg_count.
- R8: msg_avail is 1 exactly when msg_count is nonzero.
- R9: rd_byte combinationally returns the stored byte at (start of the oldest message + rd_offset) modulo 64, so a message wrapping past the end of storage reads contiguously.
- R10: head_len and head_overrun show the stored length and overrun flag of the oldest message, including a message stored with overrun set, and are 0 when no message is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_byte_valid | input | 1 | A received payload byte is offered this cycle |
| wr_byte | input | 8 | Payload byte |
| frame_end | input | 1 | Single-cycle strobe marking the end of a received frame |
| release_req | input | 1 | Single-cycle pulse freeing the oldest message |
| rd_offset | input | 6 | Byte offset within the oldest message |
| rd_byte | output | 8 | Byte at the oldest message start plus rd_offset |
| head_len | output | 7 | Stored length of the oldest message |
| head_overrun | output | 1 | Overrun flag of the oldest message |
| byte_count | output | 7 | Bytes currently held, 0 to 64 |
| msg_count | output | 6 | Messages currently held, 0 to 32 |
| byte_full | output | 1 | Byte store holds 64 bytes |
| msg_avail | output | 1 | At least one message is held |
| msg_drop | output | 1 | One-cycle pulse: a frame was lost for lack of a descriptor slot |

## Verification
The checks assume that wr_byte_valid and frame_end are never high in the same cycle. The end-of-frame strobe follows the last byte; it does not carry a byte. The checks also assume that release_req is a single-cycle pulse whose effect is judged against the occupancy seen before that edge. The stimulus draws frame_end only in cycles where no byte is offered, and it drives every input for exactly one cycle. Release pulses may land together with a byte write or a frame end, so the simultaneous-update paths are exercised, while the exclusive pair is never driven together. Phases with few releases drive the store into byte-full and descriptor-full conditions.

// File: rtl/crx_pkg.sv
// Package: default sizes shared by the receive message FIFO and its checker.
// Assumes both depths are powers of two so pointer arithmetic wraps naturally.
package crx_pkg;
    localparam int unsigned DEF_DATA_W     = 8;
    localparam int unsigned DEF_BYTE_DEPTH = 64;
    localparam int unsigned DEF_MSG_DEPTH  = 32;
endpackage

// File: rtl/crx_store.sv
// Module: crx_store
// Simple storage array with one synchronous write port and one asynchronous
// read port. It holds no reset state; the owner tracks which entries are valid.
// It assumes DEPTH is a power of two that matches the address width.
module crx_store #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Write the addressed entry.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read.
    assign rdata = mem[raddr];
endmodule

// File: rtl/crx_msg_track.sv
// Module: crx_msg_track
// Accumulates the length and the overrun flag of the message now being
// received. Both clear on the frame-end strobe. It assumes a byte offer and
// frame_end never coincide.
module crx_msg_track #(
    parameter int unsigned LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_ok,
    input  logic             byte_lost,
    input  logic             frame_end,
    output logic [LEN_W-1:0] cur_len,
    output logic             cur_ovr
);
    // Count kept bytes and remember any byte lost since the last frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_end) begin
            cur_len <= '0;
            cur_ovr <= 1'b0;
        end else begin
            if (byte_ok) begin
                cur_len <= cur_len + LEN_W'(1);
            end
            if (byte_lost) begin
                cur_ovr <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/can_rx_msg_fifo.sv
// Module: can_rx_msg_fifo
// Receive buffer for whole CAN messages. Payload bytes go into a circular
// byte store. A descriptor (stored length and overrun flag) goes into a
// circular descriptor store on frame end. The oldest message is readable by
// offset, and a release pulse frees it as a unit.
// Assumptions: power-of-two depths; wr_byte_valid and frame_end are
// exclusive; release_req is a single-cycle pulse.
module can_rx_msg_fifo #(
    parameter int unsigned DATA_W     = crx_pkg::DEF_DATA_W,
    parameter int unsigned BYTE_DEPTH = crx_pkg::DEF_BYTE_DEPTH,
    parameter int unsigned MSG_DEPTH  = crx_pkg::DEF_MSG_DEPTH,
    localparam int unsigned BAW       = $clog2(BYTE_DEPTH),
    localparam int unsigned MAW       = $clog2(MSG_DEPTH),
    localparam int unsigned CNT_W     = BAW + 1,
    localparam int unsigned MCNT_W    = MAW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_byte_valid,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              frame_end,
    input  logic              release_req,
    input  logic [BAW-1:0]    rd_offset,
    output logic [DATA_W-1:0] rd_byte,
    output logic [CNT_W-1:0]  head_len,
    output logic              head_overrun,
    output logic [CNT_W-1:0]  byte_count,
    output logic [MCNT_W-1:0] msg_count,
    output logic              byte_full,
    output logic              msg_avail,
    output logic              msg_drop
);
    localparam int unsigned INFO_W = CNT_W + 1;

    logic [BAW-1:0]    wr_ptr, rd_ptr;
    logic [MAW-1:0]    info_wr, info_rd;
    logic [CNT_W-1:0]  cur_len;
    logic              cur_ovr;
    logic [INFO_W-1:0] head_info;
    logic [CNT_W-1:0]  head_len_raw;
    logic              byte_ok, byte_lost, info_full, msg_ok, msg_lost, rel_ok;
    logic [CNT_W-1:0]  rel_len, lost_len;

    // Decode this cycle's accepted and refused operations from the current occupancy.
    always_comb begin
        byte_full    = (byte_count == CNT_W'(BYTE_DEPTH));
        info_full    = (msg_count == MCNT_W'(MSG_DEPTH));
        msg_avail    = (msg_count != '0);
        byte_ok      = wr_byte_valid && !byte_full;
        byte_lost    = wr_byte_valid && byte_full;
        msg_ok       = frame_end && !info_full;
        msg_lost     = frame_end && info_full;
        rel_ok       = release_req && msg_avail;
        head_len_raw = head_info[CNT_W-1:0];
        rel_len      = rel_ok ? head_len_raw : '0;
        lost_len     = msg_lost ? cur_len : '0;
    end

    // Byte store: payload at the tail, read at head start plus offset.
    crx_store #(.WIDTH(DATA_W), .DEPTH(BYTE_DEPTH)) u_bytes (
        .clk   (clk),
        .we    (byte_ok),
        .waddr (wr_ptr),
        .wdata (wr_byte),
        .raddr (rd_ptr + rd_offset),
        .rdata (rd_byte)
    );

    // Descriptor store: one {overrun, length} entry per recorded message.
    crx_store #(.WIDTH(INFO_W), .DEPTH(MSG_DEPTH)) u_info (
        .clk   (clk),
        .we    (msg_ok),
        .waddr (info_wr),
        .wdata ({cur_ovr, cur_len}),
        .raddr (info_rd),
        .rdata (head_info)
    );

    // Length and overrun of the message in progress.
    crx_msg_track #(.LEN_W(CNT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_ok   (byte_ok),
        .byte_lost (byte_lost),
        .frame_end (frame_end),
        .cur_len   (cur_len),
        .cur_ovr   (cur_ovr)
    );

    // Advance pointers and occupancy; a lost frame rewinds its bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            info_wr    <= '0;
            info_rd    <= '0;
            byte_count <= '0;
            msg_count  <= '0;
            msg_drop   <= 1'b0;
        end else begin
            wr_ptr     <= wr_ptr + BAW'(byte_ok) - lost_len[BAW-1:0];
            rd_ptr     <= rd_ptr + rel_len[BAW-1:0];
            info_wr    <= info_wr + MAW'(msg_ok);
            info_rd    <= info_rd + MAW'(rel_ok);
            byte_count <= byte_count + CNT_W'(byte_ok) - rel_len - lost_len;
            msg_count  <= msg_count + MCNT_W'(msg_ok) - MCNT_W'(rel_ok);
            msg_drop   <= msg_lost;
        end
    end

    // Present the oldest descriptor, blanked when nothing is held.
    assign head_len     = msg_avail ? head_len_raw : '0;
    assign head_overrun = msg_avail && head_info[INFO_W-1];
endmodule

// File: rtl/can_rx_msg_fifo_chk.sv
// Module: can_rx_msg_fifo_chk
// Property checker for can_rx_msg_fifo, bound to every instance of it.
// It sees only the ports and assumes the input rules in the header of the top module.
module can_rx_msg_fifo_chk #(
    parameter int unsigned BYTE_DEPTH = crx_pkg::DEF_BYTE_DEPTH,
    parameter int unsigned MSG_DEPTH  = crx_pkg::DEF_MSG_DEPTH,
    localparam int unsigned CNT_W     = $clog2(BYTE_DEPTH) + 1,
    localparam int unsigned MCNT_W    = $clog2(MSG_DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_byte_valid,
    input logic              frame_end,
    input logic              release_req,
    input logic [CNT_W-1:0]  byte_count,
    input logic [MCNT_W-1:0] msg_count,
    input logic              msg_avail,
    input logic              msg_drop
);
    assert_write_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_valid && byte_count < CNT_W'(BYTE_DEPTH) && !release_req
        |=> byte_count == $past(byte_count) + 1'b1);

    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte_valid && byte_count == CNT_W'(BYTE_DEPTH) && !release_req
        |=> byte_count == CNT_W'(BYTE_DEPTH));

    assert_byte_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_count <= CNT_W'(BYTE_DEPTH));

    assert_msg_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && msg_count < MCNT_W'(MSG_DEPTH) && !release_req
        |=> msg_count == $past(msg_count) + 1'b1);

    assert_msg_lost_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && msg_count == MCNT_W'(MSG_DEPTH) |=> msg_drop);

    assert_drop_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end |=> !msg_drop);

    assert_rel_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        release_req && msg_count != '0 && !frame_end
        |=> msg_count == $past(msg_count) - 1'b1);

    assert_empty_rel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        release_req && msg_count == '0 && !wr_byte_valid && !frame_end
        |=> $stable(byte_count) && msg_count == '0);

    assert_avail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        msg_avail == (msg_count != '0));
endmodule

bind can_rx_msg_fifo can_rx_msg_fifo_chk #(
    .BYTE_DEPTH(BYTE_DEPTH),
    .MSG_DEPTH (MSG_DEPTH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_byte_valid(wr_byte_valid),
    .frame_end    (frame_end),
    .release_req  (release_req),
    .byte_count   (byte_count),
    .msg_count    (msg_count),
    .msg_avail    (msg_avail),
    .msg_drop     (msg_drop)
);

// File: tb/can_rx_msg_fifo_bench.sv
// Bench for can_rx_msg_fifo. A queue-based reference model is updated per
// operation. Directed corner cases are followed by seeded random traffic.
module can_rx_msg_fifo_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES = 64;
    localparam int NMSGS  = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_byte_valid = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       frame_end = 1'b0;
    logic       release_req = 1'b0;
    logic [5:0] rd_offset = '0;
    logic [7:0] rd_byte;
    logic [6:0] head_len;
    logic       head_overrun;
    logic [6:0] byte_count;
    logic [5:0] msg_count;
    logic       byte_full, msg_avail, msg_drop;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model.
    byte unsigned data_q[$];
    byte unsigned cur_q[$];
    int           len_q[$];
    bit           ovr_q[$];
    bit           cur_ovr = 1'b0;
    bit           exp_drop = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_rx_msg_fifo u_can_rx_msg_fifo (
        .clk(clk), .rst_n(rst_n), .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte),
        .frame_end(frame_end), .release_req(release_req), .rd_offset(rd_offset),
        .rd_byte(rd_byte), .head_len(head_len), .head_overrun(head_overrun),
        .byte_count(byte_count), .msg_count(msg_count), .byte_full(byte_full),
        .msg_avail(msg_avail), .msg_drop(msg_drop)
    );

    function automatic int exp_bytes();
        return data_q.size() + cur_q.size();
    endfunction

    function automatic int exp_head_len();
        return (len_q.size() != 0) ? len_q[0] : 0;
    endfunction

    function automatic int exp_head_ovr();
        return (ovr_q.size() != 0) ? int'(ovr_q[0]) : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state(string req);
        chk(req, int'(byte_count), exp_bytes());
        chk(req, int'(msg_count), len_q.size());
        chk("R8", int'(msg_avail), int'(len_q.size() != 0));
        chk(req, int'(byte_full), int'(exp_bytes() == NBYTES));
        chk("R10", int'(head_len), exp_head_len());
        chk("R10", int'(head_overrun), exp_head_ovr());
        chk("R5", int'(msg_drop), int'(exp_drop));
    endtask

    // One clock of stimulus with the model updated from the pre-edge state.
    task automatic op(bit wr, byte unsigned b, bit fe, bit rel, string req);
        int total = exp_bytes();
        int nm = len_q.size();
        wr_byte_valid = wr; wr_byte = b; frame_end = fe; release_req = rel;
        @(negedge clk);
        wr_byte_valid = 1'b0; frame_end = 1'b0; release_req = 1'b0;
        if (wr) begin
            if (total < NBYTES) cur_q.push_back(b);
            else cur_ovr = 1'b1;
        end
        if (rel && nm > 0) begin
            int l = len_q.pop_front();
            void'(ovr_q.pop_front());
            for (int i = 0; i < l; i++) void'(data_q.pop_front());
        end
        exp_drop = 1'b0;
        if (fe) begin
            if (nm < NMSGS) begin
                len_q.push_back(cur_q.size());
                ovr_q.push_back(cur_ovr);
                foreach (cur_q[i]) data_q.push_back(cur_q[i]);
            end else begin
                exp_drop = 1'b1;
            end
            cur_q.delete();
            cur_ovr = 1'b0;
        end
        check_state(req);
    endtask

    // Read the whole oldest message through the offset window.
    task automatic check_head_bytes();
        for (int i = 0; i < exp_head_len(); i++) begin
            rd_offset = 6'(i);
            @(negedge clk);
            chk("R9", int'(rd_byte), int'(data_q[i]));
        end
        rd_offset = '0;
    endtask

    task automatic send_msg(int n, byte unsigned base);
        for (int i = 0; i < n; i++) op(1'b1, byte'(base + i), 1'b0, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b0, "R4");
    endtask

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_state("R1");

        // R2 / R4 / R9: a short message
        send_msg(5, 8'h10);
        chk("R4", int'(head_len), 5);
        check_head_bytes();

        // R6 then R7: release, then release on empty
        op(1'b0, 8'h00, 1'b0, 1'b1, "R6");
        op(1'b0, 8'h00, 1'b0, 1'b1, "R7");
        chk("R7", int'(byte_count), 0);

        // R3: overfill; second message keeps 24 bytes and carries overrun
        send_msg(40, 8'h40);
        send_msg(30, 8'h80);
        chk("R3", int'(byte_count), 64);
        op(1'b0, 8'h00, 1'b0, 1'b1, "R6");
        chk("R10", int'(head_overrun), 1);
        chk("R3", int'(head_len), 24);
        check_head_bytes();   // R9: this message wraps past the end of storage
        op(1'b0, 8'h00, 1'b0, 1'b1, "R6");

        // R5: fill all descriptor slots with empty messages, then lose one
        for (int k = 0; k < NMSGS; k++) op(1'b0, 8'h00, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 3; i++) op(1'b1, byte'(8'hC0 + i), 1'b0, 1'b0, "R2");
        op(1'b0, 8'h00, 1'b1, 1'b0, "R5");
        chk("R5", int'(byte_count), 0);
        op(1'b0, 8'h00, 1'b0, 1'b0, "R5");
        for (int k = 0; k < NMSGS; k++) op(1'b0, 8'h00, 1'b0, 1'b1, "R6");

        // Seeded random traffic with release-rate phases
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom % 100);
            int relp = ((n / 500) % 2 == 0) ? 4 : 35;
            bit wr = (r < 60);
            bit fe = !wr && (r < 80);
            bit rel = (int'($urandom % 100) < relp);
            op(wr, byte'($urandom), fe, rel, "R6");
            if (n % 40 == 0) check_head_bytes();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule